// File: doc/BRIEF.md
# Dual Cascadable Event Counter with Byte-Wide Snapshot Readout

This block counts events on two separate count inputs with two 16-bit up counters, called A and B. Each counter steps by one on every rising edge of its own count input and wraps to zero after its maximum value. Counter B also has an active-low enable. Counter A drives an active-low flag that goes low while A sits at its maximum value. If the same event input feeds both counters and that flag is wired to B's enable, the pair behaves as one 32-bit counter.

A rising edge on the sample input copies both counts into a 32-bit snapshot register at the same moment. The snapshot keeps that value until the next sample edge, so the counters can go on running while software reads the result. The snapshot is read one byte at a time over an 8-bit bus, using four active-low byte selects. The bus floats when no select is active. Reading both counts therefore takes four byte accesses.

All logic runs on one system clock. The count and sample inputs come in asynchronously; each passes through a two-stage synchronizer and then a rising-edge detector. The shared active-low clear takes effect at once, and its release is synchronized to the clock.

Top module: `dual_tally_snap`

## Requirements
- R1: While `clrN` is low, both counters and the snapshot are zero, and this happens at once, with no clock edge needed. After release, `carryN` is 1, `selErr` is 0, and `busOut` is high-impedance while all selects are high.
- R2: Counter A increments by exactly one for each rising edge of `cntAIn`. Holding `cntAIn` high adds only one count.
- R3: Counter B increments by one for each rising edge of `cntBIn` while `bEnN` is 0. While `bEnN` is 1, edges on `cntBIn` leave B unchanged.
- R4: `carryN` is 0 exactly while counter A holds 0xFFFF, and is 1 at every other value.
- R5: A counter at 0xFFFF goes to 0x0000 on its next count edge. It does not saturate.
- R6: With both counters fed from one input and `carryN` tied to `bEnN`, B advances exactly once, on the edge that takes A from 0xFFFF to 0x0000, and at no other edge.
- R7: A rising edge of `sampleIn` captures both counters into the snapshot. Later count edges do not change the snapshot until the next sample edge.
- R8: A single low select puts one snapshot byte on `busOut`. `selN[0]` gives A bits 7:0, `selN[1]` gives A bits 15:8, `selN[2]` gives B bits 7:0 and `selN[3]` gives B bits 15:8. With `selN` = 4'b1111 the bus is high-impedance.
- R9: If two or more selects are low, the lowest-numbered low select wins and `selErr` is 1. With one select low, or none, `selErr` is 0.
- R10: If a count edge and a sample edge reach the block in the same clock, the snapshot holds the count from before that increment.
- R11: A count input that rises before clock edge k has its effect, including a change of `carryN`, visible after edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clrN | input | 1 | Asynchronous active-low clear of both counters and the snapshot |
| cntAIn | input | 1 | Count input of counter A, asynchronous, counts on rising edges |
| cntBIn | input | 1 | Count input of counter B, asynchronous, counts on rising edges |
| bEnN | input | 1 | Active-low count enable of counter B |
| sampleIn | input | 1 | Snapshot strobe, asynchronous, captures on rising edges |
| selN | input | 4 | Active-low one-hot byte selects for the snapshot |
| busOut | output | 8 | Selected snapshot byte, high-impedance when no select is low |
| carryN | output | 1 | Low while counter A holds its maximum value |
| selErr | output | 1 | High while more than one byte select is low |

## Verification
A count or sample edge reaches the counters or the snapshot three clock edges after the input rises: two synchronizer edges, then the edge that updates the register. The bench drives inputs on falling edges and waits at least four cycles before it samples a count. The one latency test counts edges one by one and samples `carryN` at each falling edge in between. `busOut` and `selErr` follow `selN` and the snapshot without a clock, so they are read one time unit after the selects change. The clear is checked the same way, one time unit after it asserts and with no clock edge in between.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  // One-cycle strobes issued by the control path to the datapath
  typedef struct packed {
    logic incA;
    logic incB;
    logic capture;
  } strobe_t;
endpackage

// File: rtl/dtc_ctrl.sv
module dtc_ctrl
  import dtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    clrN,
  input  logic    cntAIn,
  input  logic    cntBIn,
  input  logic    sampleIn,
  output logic    rstN,
  output strobe_t strobes
);
  localparam int NUM_IN = 3;

  // Clear: asserts at once, releases after SYNC_STAGES clock edges
  logic [SYNC_STAGES-1:0] rstPipe;
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) rstPipe <= '0;
    else       rstPipe <= {rstPipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rstN = rstPipe[SYNC_STAGES-1];

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] rise;
  assign rawIn = {sampleIn, cntBIn, cntAIn};

  for (genvar g = 0; g < NUM_IN; g++) begin : gSync
    logic [SYNC_STAGES-1:0] pipe;
    logic                   prevLvl;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pipe    <= '0;
        prevLvl <= 1'b0;
      end else begin
        pipe    <= {pipe[SYNC_STAGES-2:0], rawIn[g]};
        prevLvl <= pipe[SYNC_STAGES-1];
      end
    end
    assign rise[g] = pipe[SYNC_STAGES-1] & ~prevLvl;
  end

  assign strobes.incA    = rise[0];
  assign strobes.incB    = rise[1];
  assign strobes.capture = rise[2];

  // R2
  inc_a_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incA |=> !strobes.incA);
  // R7
  capture_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !strobes.capture);
endmodule

// File: rtl/dtc_datapath.sv
module dtc_datapath
  import dtc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NUM_CNT = 2,
  localparam int SNAP_W  = NUM_CNT * CNT_W,
  localparam int NUM_SEL = SNAP_W / BYTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic               bEnN,
  input  logic [NUM_SEL-1:0] selN,
  output logic               carryN,
  output logic [BYTE_W-1:0]  dataOut,
  output logic               outEn,
  output logic               selErr
);
  logic [NUM_CNT-1:0] stepEn;
  logic [SNAP_W-1:0]  cntFlat;
  logic [SNAP_W-1:0]  snap;

  assign stepEn[0] = strobes.incA;
  assign stepEn[1] = strobes.incB & ~bEnN;

  for (genvar c = 0; c < NUM_CNT; c++) begin : gCnt
    logic [CNT_W-1:0] cntVal;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          cntVal <= '0;
      else if (stepEn[c]) cntVal <= cntVal + 1'b1;
    end
    assign cntFlat[c*CNT_W +: CNT_W] = cntVal;
  end

  assign carryN = ~(&cntFlat[CNT_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                snap <= '0;
    else if (strobes.capture) snap <= cntFlat;
  end

  // Lowest-numbered low select wins: scan downward so it is assigned last
  always_comb begin
    dataOut = '0;
    for (int i = NUM_SEL - 1; i >= 0; i--) begin
      if (!selN[i]) dataOut = snap[i*BYTE_W +: BYTE_W];
    end
  end

  assign outEn  = ~(&selN);
  assign selErr = ($countones(~selN) > 1);

  // R2
  a_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incA && !(&cntFlat[CNT_W-1:0])) |=>
      cntFlat[CNT_W-1:0] == $past(cntFlat[CNT_W-1:0]) + 1'b1);
  // R5
  a_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incA && (&cntFlat[CNT_W-1:0])) |=> cntFlat[CNT_W-1:0] == '0);
  // R3
  b_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bEnN || !strobes.incB) |=> $stable(cntFlat[SNAP_W-1:CNT_W]));
  // R4
  carry_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(carryN) |-> $past(strobes.incA));
  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(snap));
  // R9
  sel_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    selErr |-> (outEn && !$onehot0(~selN)));
endmodule

// File: rtl/dual_tally_snap.sv
module dual_tally_snap
  import dtc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_SEL    = 2 * CNT_W / BYTE_W
) (
  input  logic               clk,
  input  logic               clrN,
  input  logic               cntAIn,
  input  logic               cntBIn,
  input  logic               bEnN,
  input  logic               sampleIn,
  input  logic [NUM_SEL-1:0] selN,
  output wire  [BYTE_W-1:0]  busOut,
  output logic               carryN,
  output logic               selErr
);
  logic              rstN;
  strobe_t           strobes;
  logic [BYTE_W-1:0] dataOut;
  logic              outEn;

  dtc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk      (clk),
    .clrN     (clrN),
    .cntAIn   (cntAIn),
    .cntBIn   (cntBIn),
    .sampleIn (sampleIn),
    .rstN     (rstN),
    .strobes  (strobes)
  );

  dtc_datapath #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .bEnN    (bEnN),
    .selN    (selN),
    .carryN  (carryN),
    .dataOut (dataOut),
    .outEn   (outEn),
    .selErr  (selErr)
  );

  assign busOut = outEn ? dataOut : {BYTE_W{1'bz}};
endmodule

// File: tb/tb_dual_tally_snap.sv
module tb_dual_tally_snap;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clrN = 1'b0;
  logic       cntAReg = 1'b0, cntBReg = 1'b0, sampleIn = 1'b0;
  logic       bEnReg = 1'b1;
  logic       chainMode = 1'b0;
  logic [3:0] selN = 4'b1111;
  wire  [7:0] busOut;
  logic       carryN, selErr;
  logic       cntBIn, bEnN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign cntBIn = chainMode ? cntAReg : cntBReg;
  assign bEnN   = chainMode ? carryN  : bEnReg;

  dual_tally_snap dut (
    .clk(clk), .clrN(clrN), .cntAIn(cntAReg), .cntBIn(cntBIn), .bEnN(bEnN),
    .sampleIn(sampleIn), .selN(selN), .busOut(busOut), .carryN(carryN),
    .selErr(selErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(bit a, bit b, bit s);
    @(negedge clk);
    cntAReg = a; cntBReg = b; sampleIn = s;
    @(negedge clk);
    cntAReg = 1'b0; cntBReg = 1'b0; sampleIn = 1'b0;
  endtask

  task automatic readByte(int idx, output logic [7:0] v);
    @(negedge clk);
    selN = ~(4'b0001 << idx);
    #1 v = busOut;
    selN = 4'b1111;
  endtask

  task automatic readSnap(output logic [15:0] a, output logic [15:0] b);
    logic [7:0] v0, v1, v2, v3;
    readByte(0, v0); readByte(1, v1); readByte(2, v2); readByte(3, v3);
    a = {v1, v0}; b = {v3, v2};
  endtask

  task automatic sampleRead(output logic [15:0] a, output logic [15:0] b);
    settle();
    pulse(1'b0, 1'b0, 1'b1);
    settle();
    readSnap(a, b);
  endtask

  task automatic t_reset();
    logic [15:0] a, b;
    clrN = 1'b0;
    repeat (3) @(negedge clk);
    clrN = 1'b1;
    settle();
    #1;
    check("R1 bus idle", {24'h0, busOut}, {24'h0, 8'hzz});
    check("R1 carryN", {31'h0, carryN}, 32'd1);
    check("R1 selErr", {31'h0, selErr}, 32'd0);
    readSnap(a, b);
    check("R1 snapshot after clear", {b, a}, 32'h0);
  endtask

  task automatic t_countA();
    logic [15:0] a, b;
    for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0, 1'b0);
    sampleRead(a, b);
    check("R2 A after 5 edges", {16'h0, a}, 32'd5);
    check("R2 B untouched", {16'h0, b}, 32'd0);
    @(negedge clk); cntAReg = 1'b1;
    repeat (10) @(negedge clk); cntAReg = 1'b0;
    sampleRead(a, b);
    check("R2 held level counts once", {16'h0, a}, 32'd6);
  endtask

  task automatic t_countB();
    logic [15:0] a, b;
    bEnReg = 1'b0;
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1, 1'b0);
    sampleRead(a, b);
    check("R3 B enabled", {16'h0, b}, 32'd3);
    bEnReg = 1'b1;
    for (int i = 0; i < 4; i++) pulse(1'b0, 1'b1, 1'b0);
    sampleRead(a, b);
    check("R3 B disabled ignores edges", {16'h0, b}, 32'd3);
    check("R3 A unaffected", {16'h0, a}, 32'd6);
  endtask

  task automatic t_snapHold();
    logic [15:0] a, b;
    pulse(1'b1, 1'b0, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    settle();
    readSnap(a, b);
    check("R7 snapshot holds", {16'h0, a}, 32'd6);
    sampleRead(a, b);
    check("R7 new capture", {16'h0, a}, 32'd8);
  endtask

  task automatic t_priority();
    @(negedge clk); selN = 4'b1010; #1;
    check("R9 sel0+sel2 picks A low", {24'h0, busOut}, 32'h08);
    check("R9 error flag", {31'h0, selErr}, 32'd1);
    @(negedge clk); selN = 4'b0011; #1;
    check("R9 sel2+sel3 picks B low", {24'h0, busOut}, 32'h03);
    check("R9 error flag pair", {31'h0, selErr}, 32'd1);
    @(negedge clk); selN = 4'b1011; #1;
    check("R9 single select no error", {31'h0, selErr}, 32'd0);
    check("R8 sel2 gives B low", {24'h0, busOut}, 32'h03);
    @(negedge clk); selN = 4'b1111; #1;
    check("R8 all high floats", {24'h0, busOut}, {24'h0, 8'hzz});
    check("R9 no select no error", {31'h0, selErr}, 32'd0);
  endtask

  task automatic t_sameCycle();
    logic [15:0] a, b;
    pulse(1'b1, 1'b0, 1'b1);
    settle();
    readSnap(a, b);
    check("R10 capture sees pre-increment", {16'h0, a}, 32'd8);
    sampleRead(a, b);
    check("R10 increment landed", {16'h0, a}, 32'd9);
  endtask

  task automatic t_clear();
    @(negedge clk); selN = 4'b1110; #1;
    check("R1 before clear", {24'h0, busOut}, 32'h09);
    clrN = 1'b0; #1;
    check("R1 clear acts without clock", {24'h0, busOut}, 32'h00);
    @(negedge clk); selN = 4'b1111; clrN = 1'b1;
    settle();
  endtask

  task automatic t_chain();
    logic [15:0] a, b;
    chainMode = 1'b1;
    for (int i = 0; i < 65534; i++) pulse(1'b1, 1'b0, 1'b0);
    sampleRead(a, b);
    check("R6 chain A at FFFE", {16'h0, a}, 32'hFFFE);
    check("R6 chain B still zero", {16'h0, b}, 32'h0);
    check("R4 carryN high below max", {31'h0, carryN}, 32'd1);
    @(negedge clk); cntAReg = 1'b1;
    @(negedge clk);
    check("R11 carryN after 1 edge", {31'h0, carryN}, 32'd1);
    @(negedge clk);
    check("R11 carryN after 2 edges", {31'h0, carryN}, 32'd1);
    @(negedge clk);
    check("R11 carryN after 3 edges", {31'h0, carryN}, 32'd0);
    cntAReg = 1'b0;
    sampleRead(a, b);
    check("R4 A at max", {16'h0, a}, 32'hFFFF);
    check("R8 A high byte", {24'h0, a[15:8]}, 32'hFF);
    check("R4 carryN low at max", {31'h0, carryN}, 32'd0);
    pulse(1'b1, 1'b0, 1'b0);
    sampleRead(a, b);
    check("R5 A wraps to zero", {16'h0, a}, 32'h0);
    check("R6 B advanced on rollover", {16'h0, b}, 32'd1);
    check("R4 carryN high after wrap", {31'h0, carryN}, 32'd1);
    pulse(1'b1, 1'b0, 1'b0);
    sampleRead(a, b);
    check("R6 A steps again", {16'h0, a}, 32'd1);
    check("R6 B advances only once", {16'h0, b}, 32'd1);
    chainMode = 1'b0;
  endtask

  initial begin
    t_reset();
    t_countA();
    t_countB();
    t_snapHold();
    t_priority();
    t_sameCycle();
    t_clear();
    t_chain();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule